// File: doc/BRIEF.md
# Bus Trace Capture Buffer

The block stores a running record of bus cycles in an on-chip trace memory of 256 entries, each 384 bits wide. Every cycle a capture selection says whether that cycle is skipped, stored as a 128-bit address/control record, or stored as a full record. A full record is the 128-bit address/control record plus a 256-bit data snapshot. Address records are packed three to an entry. A full record takes a whole entry. The write pointer wraps, so by default the memory keeps the latest 256 entries. In linear mode capture instead stops for good when the last entry is closed.

Capture is governed by start, stop and freeze commands, which come from trigger logic outside this block. A capture-state machine has four states:
- `CAP_IDLE` (encoding 0): after reset or clear, not yet started.
- `CAP_RUN` (1): capturing.
- `CAP_STOP` (2): paused, with the pointer kept.
- `CAP_FROZEN` (3): halted until the buffer is cleared.

Its transitions are:
- start: IDLE→RUN and STOP→RUN.
- stop: RUN→STOP.
- freeze: IDLE, RUN or STOP→FROZEN.
- fill-freeze: RUN→FROZEN in linear mode.
- clear: any state→IDLE.

The clear can come from software or from the debug port. A read port returns any entry, with its slot valid bits and its full-record flag, one cycle after the index is presented.

Top module: `trace_capture_buffer`

## Requirements
- R1: Reset, or a clear (`sw_clear_i` or `dbg_clear_i`) sampled at a clock edge, sets the pointer to 0, clears the wrapped flag, puts the state at IDLE (0), and clears every slot valid bit and every full flag. A cycle with a clear captures nothing.
- R2: A cycle is captured only when the state is RUN (1) at the clock edge. `sel_i` is decoded as follows: 00 = no sample, 01 = address record, 10 or 11 = full record. When `every_cycle_i` is high, every captured cycle is taken as a full record.
- R3: Address records go into slots 0, 1 and 2 of the entry at the pointer, in that order. Slot k occupies bits [128k+127:128k]. The pointer advances after slot 2 is filled. Writing slot 0 leaves the valid bits at 001 and the full flag at 0. Writing slot k sets valid bits 0..k.
- R4: A full record writes the address/control record to slot 0, data bits [127:0] to slot 1 and data bits [255:128] to slot 2. It sets valid to 001 and the full flag to 1. If an entry is partly filled, the full record goes to the next entry, and the unused slots of the partly filled entry stay invalid. The pointer then moves past the full record with the slot position at 0.
- R5: The pointer counts modulo 256. The wrapped flag sets the first time the pointer passes entry 255 and stays set until a clear.
- R6: Commands take effect at the next edge, with priority clear > freeze > stop > start. Start moves IDLE or STOP to RUN. Stop moves RUN to STOP. Freeze moves IDLE, RUN or STOP to FROZEN.
- R7: In STOP the pointer and the slot position are held. After a start, filling continues at the same entry and slot.
- R8: In FROZEN, start and stop have no effect and nothing is captured until a clear.
- R9: In linear mode (`linear_i` = 1), closing entry 255 moves RUN to FROZEN, with the pointer at 0 and the wrapped flag set. A full record arriving while entry 255 is partly filled closes that entry and is dropped.
- R10: `rd_entry_o`, `rd_slot_vld_o` and `rd_full_o` show the entry selected by `rd_idx_i` at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clear_i | input | 1 | Buffer clear from software |
| dbg_clear_i | input | 1 | Buffer clear from the debug port |
| start_i | input | 1 | Start/resume capture command |
| stop_i | input | 1 | Pause capture command |
| freeze_i | input | 1 | Freeze capture command |
| linear_i | input | 1 | Freeze when the buffer first fills |
| every_cycle_i | input | 1 | Take every cycle as a full record |
| sel_i | input | 2 | Per-cycle capture selection |
| addr_rec_i | input | 128 | Address/control record of the current cycle |
| data_snap_i | input | 256 | Data snapshot of the current cycle |
| rd_idx_i | input | 8 | Entry index for read-back |
| rd_entry_o | output | 384 | Entry contents, slot 2 in the top bits |
| rd_slot_vld_o | output | 3 | Valid bit per slot of the entry read |
| rd_full_o | output | 1 | Entry holds a full record |
| ptr_o | output | 8 | Current write pointer |
| wrapped_o | output | 1 | Pointer has passed entry 255 |
| state_o | output | 2 | Capture state (0 IDLE, 1 RUN, 2 STOP, 3 FROZEN) |

## Verification
A wrong capture state shows on `state_o` one edge after the command. If capture continues in a state that should hold, `ptr_o` moves within at most three address samples. A wrong slot position cannot be seen on the status port. It shows only when the entries are read back, as valid bits or data in the wrong slot. For that reason the bench compares the full memory image against its own model several times during long random runs, and after each directed packing case.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_RUN    = 2'd1,
        CAP_STOP   = 2'd2,
        CAP_FROZEN = 2'd3
    } cap_state_e;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_ADDR = 2'b01;

endpackage

// File: rtl/trace_cmd_fsm.sv
module trace_cmd_fsm
    import trace_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       freeze_i,
    input  logic       fill_freeze_i,
    output cap_state_e state_o,
    output logic       capture_en_o
);

    cap_state_e state_q;
    cap_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: clear > freeze > stop > start
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = CAP_IDLE;
        end else begin
            unique case (state_q)
                CAP_IDLE: begin
                    if (freeze_i)                 state_d = CAP_FROZEN;
                    else if (start_i && !stop_i)  state_d = CAP_RUN;
                end
                CAP_RUN: begin
                    if (freeze_i || fill_freeze_i) state_d = CAP_FROZEN;
                    else if (stop_i)               state_d = CAP_STOP;
                end
                CAP_STOP: begin
                    if (freeze_i)                 state_d = CAP_FROZEN;
                    else if (start_i && !stop_i)  state_d = CAP_RUN;
                end
                CAP_FROZEN: begin
                    state_d = CAP_FROZEN;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        state_o      = state_q;
        capture_en_o = (state_q == CAP_RUN);
    end

endmodule

// File: rtl/trace_packer.sv
module trace_packer
    import trace_buf_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int SLOTS   = 3,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             capture_en_i,
    input  logic [1:0]       sel_i,
    input  logic             every_cycle_i,
    input  logic             linear_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [SLOTS-1:0] slot_we_o,
    output logic             wr_full_rec_o,
    output logic [SLOTS-1:0] vld_o,
    output logic             fill_freeze_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wrapped_o
);

    localparam logic [PTR_W-1:0]  LAST_IDX  = PTR_W'(ENTRIES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [PTR_W-1:0]  ptr_q, ptr_d, tgt;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              wrap_q, wrap_d;
    logic              take_full, take_addr, open_entry, at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            slot_q <= '0;
            wrap_q <= 1'b0;
        end else if (clr_i) begin
            ptr_q  <= '0;
            slot_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            slot_q <= slot_d;
            wrap_q <= wrap_d;
        end
    end

    always_comb begin
        take_full  = capture_en_i && (every_cycle_i || sel_i[1]);
        take_addr  = capture_en_i && !take_full && (sel_i == SEL_ADDR);
        open_entry = (slot_q != '0);
        at_last    = (ptr_q == LAST_IDX);
        tgt        = open_entry ? (ptr_q + PTR_W'(1)) : ptr_q;

        wr_en_o       = 1'b0;
        wr_idx_o      = ptr_q;
        slot_we_o     = '0;
        wr_full_rec_o = 1'b0;
        vld_o         = '0;
        fill_freeze_o = 1'b0;
        ptr_d         = ptr_q;
        slot_d        = slot_q;
        wrap_d        = wrap_q;

        if (take_addr) begin
            wr_en_o   = 1'b1;
            slot_we_o = SLOTS'(1) << slot_q;
            for (int k = 0; k < SLOTS; k++) begin
                vld_o[k] = (k <= int'(slot_q));
            end
            if (slot_q == LAST_SLOT) begin
                slot_d = '0;
                ptr_d  = ptr_q + PTR_W'(1);
                if (at_last) begin
                    wrap_d        = 1'b1;
                    fill_freeze_o = linear_i;
                end
            end else begin
                slot_d = slot_q + SLOT_W'(1);
            end
        end else if (take_full) begin
            if (linear_i && open_entry && at_last) begin
                // last entry closed by the full record; record dropped
                ptr_d         = '0;
                slot_d        = '0;
                wrap_d        = 1'b1;
                fill_freeze_o = 1'b1;
            end else begin
                wr_en_o       = 1'b1;
                wr_idx_o      = tgt;
                slot_we_o     = '1;
                wr_full_rec_o = 1'b1;
                vld_o         = SLOTS'(1);
                ptr_d         = tgt + PTR_W'(1);
                slot_d        = '0;
                if ((tgt == LAST_IDX) || (open_entry && at_last)) begin
                    wrap_d = 1'b1;
                end
                fill_freeze_o = linear_i && (tgt == LAST_IDX);
            end
        end
    end

    assign ptr_o     = ptr_q;
    assign wrapped_o = wrap_q;

endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int ENTRIES = 256,
    parameter int SLOTS   = 3,
    parameter int REC_W   = 128,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int LINE_W = SLOTS * REC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [SLOTS-1:0]  slot_we_i,
    input  logic              full_rec_i,
    input  logic [SLOTS-1:0]  vld_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [LINE_W-1:0] rd_line_o,
    output logic [SLOTS-1:0]  rd_vld_o,
    output logic              rd_full_o
);

    // One bank per slot, registered read
    for (genvar s = 0; s < SLOTS; s++) begin : g_bank
        logic [REC_W-1:0] bank [ENTRIES];
        logic [REC_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en_i && slot_we_i[s]) begin
                bank[wr_idx_i] <= wr_line_i[s*REC_W +: REC_W];
            end
            rd_q <= bank[rd_idx_i];
        end

        assign rd_line_o[s*REC_W +: REC_W] = rd_q;
    end

    // Slot valid bits and full flags in flops for one-cycle clear
    logic [SLOTS-1:0]   vld_q [ENTRIES];
    logic [ENTRIES-1:0] full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) vld_q[e] <= '0;
            full_q <= '0;
        end else if (clr_i) begin
            for (int e = 0; e < ENTRIES; e++) vld_q[e] <= '0;
            full_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i]  <= vld_i;
            full_q[wr_idx_i] <= full_rec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_o  <= '0;
            rd_full_o <= 1'b0;
        end else begin
            rd_vld_o  <= vld_q[rd_idx_i];
            rd_full_o <= full_q[rd_idx_i];
        end
    end

endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
    import trace_buf_pkg::*;
#(
    parameter int ENTRIES  = 256,
    parameter int SLOTS    = 3,
    parameter int REC_W    = 128,
    localparam int PTR_W   = $clog2(ENTRIES),
    localparam int DATA_W  = (SLOTS - 1) * REC_W,
    localparam int ENTRY_W = SLOTS * REC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_clear_i,
    input  logic               dbg_clear_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               freeze_i,
    input  logic               linear_i,
    input  logic               every_cycle_i,
    input  logic [1:0]         sel_i,
    input  logic [REC_W-1:0]   addr_rec_i,
    input  logic [DATA_W-1:0]  data_snap_i,
    input  logic [PTR_W-1:0]   rd_idx_i,
    output logic [ENTRY_W-1:0] rd_entry_o,
    output logic [SLOTS-1:0]   rd_slot_vld_o,
    output logic               rd_full_o,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               wrapped_o,
    output logic [1:0]         state_o
);

    logic               clr;
    logic               capture_en;
    logic               fill_freeze;
    cap_state_e         cap_state;
    logic               wr_en;
    logic [PTR_W-1:0]   wr_idx;
    logic [SLOTS-1:0]   slot_we;
    logic               wr_full_rec;
    logic [SLOTS-1:0]   wr_vld;
    logic [ENTRY_W-1:0] wr_line;

    assign clr = sw_clear_i | dbg_clear_i;

    trace_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .freeze_i     (freeze_i),
        .fill_freeze_i(fill_freeze),
        .state_o      (cap_state),
        .capture_en_o (capture_en)
    );

    trace_packer #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .capture_en_i (capture_en),
        .sel_i        (sel_i),
        .every_cycle_i(every_cycle_i),
        .linear_i     (linear_i),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .slot_we_o    (slot_we),
        .wr_full_rec_o(wr_full_rec),
        .vld_o        (wr_vld),
        .fill_freeze_o(fill_freeze),
        .ptr_o        (ptr_o),
        .wrapped_o    (wrapped_o)
    );

    // Full record: address in slot 0, data above; address record: copy in every slot
    assign wr_line = wr_full_rec ? {data_snap_i, addr_rec_i} : {SLOTS{addr_rec_i}};

    trace_store #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .REC_W(REC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .slot_we_i (slot_we),
        .full_rec_i(wr_full_rec),
        .vld_i     (wr_vld),
        .wr_line_i (wr_line),
        .rd_idx_i  (rd_idx_i),
        .rd_line_o (rd_entry_o),
        .rd_vld_o  (rd_slot_vld_o),
        .rd_full_o (rd_full_o)
    );

    assign state_o = cap_state;

endmodule

// File: rtl/trace_capture_buffer_chk.sv
module trace_capture_buffer_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_clear_i,
    input logic             dbg_clear_i,
    input logic             start_i,
    input logic             stop_i,
    input logic             freeze_i,
    input logic [PTR_W-1:0] ptr_o,
    input logic             wrapped_o,
    input logic [1:0]       state_o
);

    logic clr;
    assign clr = sw_clear_i | dbg_clear_i;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr_o == '0 && !wrapped_o && state_o == 2'd0));

    assert_wrap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped_o && !clr) |=> wrapped_o);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (PTR_W'(ptr_o - $past(ptr_o)) <= PTR_W'(2)));

    assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && start_i && !stop_i && !freeze_i && !clr) |=> state_o == 2'd1);

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clr) |=> state_o == 2'd3);

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd1 && !clr) |=> ptr_o == $past(ptr_o));

    assert_frozen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !clr) |=> state_o == 2'd3);

endmodule

bind trace_capture_buffer trace_capture_buffer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_clear_i (sw_clear_i),
    .dbg_clear_i(dbg_clear_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .freeze_i   (freeze_i),
    .ptr_o      (ptr_o),
    .wrapped_o  (wrapped_o),
    .state_o    (state_o)
);

// File: tb/trace_capture_buffer_tb.sv
module trace_capture_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 256;
    localparam int WD_LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_clr = 1'b0, dbg_clr = 1'b0;
    logic         start = 1'b0, stop = 1'b0, frz = 1'b0;
    logic         lin = 1'b0, every = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic [127:0] ac = '0;
    logic [255:0] dat = '0;
    logic [7:0]   rd_idx = '0;
    logic [383:0] rd_entry;
    logic [2:0]   rd_vld;
    logic         rd_full;
    logic [7:0]   ptr;
    logic         wrapped;
    logic [1:0]   state;

    int nchk = 0;
    int nfail = 0;

    // model of the buffer
    logic [127:0] md [NE][3];
    logic [2:0]   mv [NE];
    logic         mf [NE];
    int           mptr = 0, mslot = 0, mst = 0;
    logic         mwrap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_capture_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .sw_clear_i(sw_clr), .dbg_clear_i(dbg_clr),
        .start_i(start), .stop_i(stop), .freeze_i(frz), .linear_i(lin),
        .every_cycle_i(every), .sel_i(sel), .addr_rec_i(ac), .data_snap_i(dat),
        .rd_idx_i(rd_idx), .rd_entry_o(rd_entry), .rd_slot_vld_o(rd_vld),
        .rd_full_o(rd_full), .ptr_o(ptr), .wrapped_o(wrapped), .state_o(state)
    );

    task automatic m_clear();
        for (int e = 0; e < NE; e++) begin mv[e] = 3'b000; mf[e] = 1'b0; end
        mptr = 0; mslot = 0; mst = 0; mwrap = 1'b0;
    endtask

    // one clock edge of the specified behaviour
    task automatic m_step();
        bit ff = 0;
        bit is_full, is_addr, open;
        int tgt;
        if (sw_clr || dbg_clr) begin m_clear(); return; end
        if (mst == 1) begin
            is_full = every || sel[1];
            is_addr = !is_full && sel == 2'b01;
            if (is_addr) begin
                md[mptr][mslot] = ac;
                for (int k = 0; k < 3; k++) mv[mptr][k] = (k <= mslot);
                mf[mptr] = 1'b0;
                if (mslot == 2) begin
                    mslot = 0;
                    if (mptr == NE-1) begin mwrap = 1'b1; ff = lin; end
                    mptr = (mptr + 1) % NE;
                end else mslot++;
            end else if (is_full) begin
                open = (mslot != 0);
                if (lin && open && mptr == NE-1) begin
                    mptr = 0; mslot = 0; mwrap = 1'b1; ff = 1;
                end else begin
                    tgt = (mptr + (open ? 1 : 0)) % NE;
                    md[tgt][0] = ac; md[tgt][1] = dat[127:0]; md[tgt][2] = dat[255:128];
                    mv[tgt] = 3'b001; mf[tgt] = 1'b1;
                    if (tgt == NE-1 || (open && mptr == NE-1)) mwrap = 1'b1;
                    ff = lin && (tgt == NE-1);
                    mptr = (tgt + 1) % NE; mslot = 0;
                end
            end
        end
        case (mst)
            0: if (frz) mst = 3; else if (start && !stop) mst = 1;
            1: if (frz || ff) mst = 3; else if (stop) mst = 2;
            2: if (frz) mst = 3; else if (start && !stop) mst = 1;
            default: mst = 3;
        endcase
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // inputs are set at a falling edge; compare status at the next falling edge
    task automatic tick(input string req);
        m_step();
        @(negedge clk);
        check(ptr == 8'(mptr) && wrapped == mwrap && state == 2'(mst), req,
              "status ptr/wrap/state", {ptr, 7'd0, wrapped, 6'd0, state},
              {8'(mptr), 7'd0, mwrap, 6'd0, 2'(mst)});
    endtask

    task automatic op(input bit st, input bit sp, input bit fz, input logic [1:0] s, input string req);
        start = st; stop = sp; frz = fz; sel = s;
        ac  = {$urandom, $urandom, $urandom, $urandom};
        dat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        tick(req);
        start = 0; stop = 0; frz = 0; sel = 2'b00;
    endtask

    task automatic clear_op(input bit dbg, input string req);
        sw_clr = !dbg; dbg_clr = dbg;
        tick(req);
        sw_clr = 0; dbg_clr = 0;
    endtask

    task automatic rd_chk(input int i, input string req);
        bit ok;
        rd_idx = 8'(i);
        op(0, 0, 0, 2'b00, req);
        ok = (rd_vld == mv[i]) && (rd_full == mf[i]);
        for (int k = 0; k < 3; k++)
            if (mf[i] || mv[i][k]) ok = ok && (rd_entry[k*128 +: 128] == md[i][k]);
        check(ok, req, $sformatf("entry %0d vld/full/data", i), {rd_vld, rd_full}, {mv[i], mf[i]});
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < NE; i++) rd_chk(i, req);
    endtask

    // watchdog
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(ptr == 0 && !wrapped && state == 2'd0, "R1", "reset status", ptr, 0);
        rd_chk(0, "R1");
        rd_chk(255, "R1");

        // R6: start from IDLE
        op(1, 0, 0, 2'b00, "R6");
        check(state == 2'd1, "R6", "state after start", state, 1);

        // R3: four address records
        for (int n = 0; n < 4; n++) op(0, 0, 0, 2'b01, "R3");
        check(ptr == 1, "R3", "ptr after four address records", ptr, 1);
        rd_chk(0, "R3");
        rd_chk(1, "R3");

        // R4: full record after partial entry
        op(0, 0, 0, 2'b10, "R4");
        check(ptr == 3, "R4", "ptr after full record", ptr, 3);
        rd_chk(1, "R4");
        rd_chk(2, "R4");

        // R2: selection none leaves pointer; every-cycle turns address into full
        op(0, 0, 0, 2'b00, "R2");
        check(ptr == 3, "R2", "no-sample keeps ptr", ptr, 3);
        every = 1; op(0, 0, 0, 2'b01, "R2"); every = 0;
        rd_chk(3, "R2");

        // R7: stop holds, start resumes
        op(0, 0, 0, 2'b01, "R7");
        op(0, 1, 0, 2'b00, "R7");
        for (int n = 0; n < 3; n++) op(0, 0, 0, 2'b01, "R7");
        check(ptr == 4 && state == 2'd2, "R7", "ptr held in STOP", ptr, 4);
        op(1, 0, 0, 2'b00, "R7");
        op(0, 0, 0, 2'b01, "R7");
        rd_chk(4, "R7");

        // R8: frozen ignores start
        op(0, 0, 1, 2'b00, "R8");
        op(1, 0, 0, 2'b01, "R8");
        op(0, 0, 0, 2'b10, "R8");
        check(state == 2'd3 && ptr == 4, "R8", "frozen holds", state, 3);
        clear_op(0, "R1");
        rd_chk(0, "R1");

        // R9: linear fill with partly filled last entry
        lin = 1;
        op(1, 0, 0, 2'b00, "R9");
        op(0, 0, 0, 2'b01, "R9");
        for (int n = 0; n < 300; n++) op(0, 0, 0, 2'b10, "R9");
        check(state == 2'd3 && ptr == 0 && wrapped, "R9", "linear freeze", {ptr, state}, 3);
        rd_chk(0, "R9");
        rd_chk(255, "R9");
        clear_op(1, "R1");
        // R9: partly filled entry 255 closed by a full record, record dropped
        op(1, 0, 0, 2'b00, "R9");
        for (int n = 0; n < 255; n++) op(0, 0, 0, 2'b10, "R9");
        op(0, 0, 0, 2'b01, "R9");
        op(0, 0, 0, 2'b10, "R9");
        check(state == 2'd3 && ptr == 0, "R9", "drop at last entry", {ptr, state}, 3);
        rd_chk(255, "R9");
        rd_chk(0, "R9");
        clear_op(0, "R1");
        lin = 0;

        // R5: circular wrap
        op(1, 0, 0, 2'b00, "R5");
        for (int n = 0; n < 257; n++) op(0, 0, 0, 2'b10, "R5");
        check(ptr == 1 && wrapped && state == 2'd1, "R5", "wrap ptr", ptr, 1);
        rd_chk(0, "R10");
        // R6: priority freeze over stop and start
        op(1, 1, 1, 2'b00, "R6");
        check(state == 2'd3, "R6", "freeze priority", state, 3);
        clear_op(0, "R6");

        // random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 1000 == 0) lin = $urandom_range(0, 1);
            sw_clr  = ($urandom % 500 == 0);
            dbg_clr = ($urandom % 500 == 0);
            every   = ($urandom % 40 == 0);
            rd_idx  = 8'($urandom);
            op(($urandom % 6 == 0), ($urandom % 20 == 0), ($urandom % 400 == 0),
               2'($urandom), "R2");
            sw_clr = 0; dbg_clr = 0; every = 0;
            if (cyc % 800 == 799) rd_all("R10");
        end
        rd_all("R3");

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule